// File: doc/BRIEF.md
# Edge-Change Interrupt Controller

This block watches a bank of digital input lines, organised as byte-wide ports, for rising and falling transitions. Each port carries two enable bytes, one for rising and one for falling edges, so every line can be armed for either direction, both or neither. A qualified transition sets a shared edge-event flag together with a sticky flag naming its direction. The block can raise an interrupt request from that flag. A further qualified transition that arrives while the edge-event flag is still pending sets an overflow flag.

Software drives the block through a small byte-addressed register interface. There is a status register, a control register that holds per-cause interrupt enables, a master enable and global rising/falling detection enables, and a write-one-to-clear register. The per-port enable bytes repeat at a fixed stride. The inputs are synchronised to the core clock, and a transition is found by comparing each synchronised line with its value one clock earlier.

Top module: `edgeirq_ctrl`

## Requirements
- R1: After reset the status, control and all per-port enable bytes read 0x00 and `irq` is low.
- R2: A 0-to-1 transition on line i, with the rising enable bit set for that line (port i/8, bit i%8) and control bit3 set, sets status bit0 (edge event) and status bit3 (rising seen).
- R3: A 1-to-0 transition on a line whose falling enable bit is set, with control bit4 set, sets status bit0 and status bit4 (falling seen).
- R4: A transition has no effect when the line's enable bit for that direction is clear, or when the matching global enable (control bit3 rising, bit4 falling) is clear.
- R5: A qualified transition that arrives while status bit0 is set, and is not coincident with an edge clear, sets status bit1 (overflow).
- R6: A write to offset 0x01 with bit3 set clears status bits 0, 3 and 4. Bit2 clears status bit1. Both may be cleared in one write. Other bits of that write have no effect.
- R7: If an edge clear and a qualified transition fall on the same clock, status bit0 stays set and no overflow is recorded.
- R8: `irq` and status bit2 are high exactly when control bit2 (master) is set and either status bit0 with control bit0, or status bit1 with control bit1, is set.
- R9: Each port's enable bytes are written independently. A write to one port leaves every other port's enable bytes unchanged.
- R10: Writing 0x00 to the control register drops `irq` on the next clock, while the status flags keep their values.
- R11: Register offsets: clear 0x01, status 0x02, control 0x03, rising enable of port n at 0x42+0x10·n, falling enable at 0x43+0x10·n. Reads return the addressed value one clock after the address is presented. The clear register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | NUM_PORTS*PORT_W | Asynchronous digital input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | PORT_W | Register write data |
| bus_rdata | output | PORT_W | Registered read data for the address of the previous clock |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the lines are held stable across the synchroniser and that the bus presents at most one write per clock. They also assume that a clear write is decoded only from the clear offset. The stimulus changes a single line at a time on the falling clock edge, then waits long enough for the transition to pass through both synchroniser stages and the history register before it reads status. Bus writes and reads are spaced so that each clock carries either a single write or a single address. The same-clock race between a clear and a transition is timed so that the write lands on the exact clock where the detector fires.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
  // Fixed register offsets (software decodes these)
  localparam int unsigned ADR_CLEAR   = 'h01;
  localparam int unsigned ADR_STATUS  = 'h02;
  localparam int unsigned ADR_CTRL    = 'h03;
  localparam int unsigned ADR_PBASE   = 'h40;
  localparam int unsigned ADR_PSTRIDE = 'h10;
  localparam int unsigned OFS_RISE    = 2;
  localparam int unsigned OFS_FALL    = 3;

  // Clear register bit positions
  localparam int unsigned CLR_OVF_BIT  = 2;
  localparam int unsigned CLR_EDGE_BIT = 3;

  // Control register, bit0 at the LSB
  typedef struct packed {
    logic fall_en;    // bit4
    logic rise_en;    // bit3
    logic master_en;  // bit2
    logic ovf_en;     // bit1
    logic edge_en;    // bit0
  } ctrl_t;

  // Status register, bit0 at the LSB
  typedef struct packed {
    logic [2:0] spare;
    logic       fall_seen;  // bit4
    logic       rise_seen;  // bit3
    logic       pending;    // bit2
    logic       ovf;        // bit1
    logic       edge_ev;    // bit0
  } status_t;
endpackage

// File: rtl/edgeirq_sync.sv
module edgeirq_sync #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] meta_q, sync_q, hist_q;
  logic [2:0]       warm_q;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      hist_q <= sync_q;
      warm_q <= {warm_q[1:0], 1'b1};
    end
  end

  // Comparisons start only once the history stage holds real samples
  assign armed = warm_q[2];
  assign rise  = armed ? (sync_q & ~hist_q) : '0;
  assign fall  = armed ? (~sync_q & hist_q) : '0;
endmodule

// File: rtl/edgeirq_regs.sv
module edgeirq_regs
  import edgeirq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PORT_W-1:0]             wdata,
  input  logic [PORT_W-1:0]             status_byte,
  output logic [NUM_PORTS*PORT_W-1:0]   rise_mask,
  output logic [NUM_PORTS*PORT_W-1:0]   fall_mask,
  output ctrl_t                         ctrl,
  output logic                          clr_edge,
  output logic                          clr_ovf,
  output logic [PORT_W-1:0]             rdata
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic [ADDR_W-1:0] port_adr(int unsigned p, int unsigned ofs);
    return ADDR_W'(ADR_PBASE + p * ADR_PSTRIDE + ofs);
  endfunction

  logic [PORT_W-1:0] rmask_q [NUM_PORTS];
  logic [PORT_W-1:0] fmask_q [NUM_PORTS];
  ctrl_t             ctrl_q;
  logic [PORT_W-1:0] rd_next;
  logic              hit_clear;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) begin
          rmask_q[gp] <= '0;
          fmask_q[gp] <= '0;
        end else if (wr) begin
          if (addr == port_adr(gp, OFS_RISE)) rmask_q[gp] <= wdata;
          if (addr == port_adr(gp, OFS_FALL)) fmask_q[gp] <= wdata;
        end
      end
      assign rise_mask[gp*PORT_W +: PORT_W] = rmask_q[gp];
      assign fall_mask[gp*PORT_W +: PORT_W] = fmask_q[gp];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr && addr == ADDR_W'(ADR_CTRL)) begin
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  assign ctrl      = ctrl_q;
  assign hit_clear = wr && (addr == ADDR_W'(ADR_CLEAR));
  assign clr_edge  = hit_clear && wdata[CLR_EDGE_BIT];
  assign clr_ovf   = hit_clear && wdata[CLR_OVF_BIT];

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADR_STATUS)) rd_next = status_byte;
    if (addr == ADDR_W'(ADR_CTRL))   rd_next = PORT_W'(ctrl_q);
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == port_adr(p, OFS_RISE)) rd_next = rmask_q[p];
      if (addr == port_adr(p, OFS_FALL)) rd_next = fmask_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/edgeirq_status.sv
module edgeirq_status
  import edgeirq_pkg::*;
#(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  input  logic [WIDTH-1:0] rise_mask,
  input  logic [WIDTH-1:0] fall_mask,
  input  ctrl_t            ctrl,
  input  logic             clr_edge,
  input  logic             clr_ovf,
  output logic             edge_q,
  output logic             ovf_q,
  output logic             rseen_q,
  output logic             fseen_q,
  output logic             any_hit,
  output logic             irq
);
  logic rise_hit, fall_hit, ovf_new;

  assign rise_hit = ctrl.rise_en && (|(rise & rise_mask));
  assign fall_hit = ctrl.fall_en && (|(fall & fall_mask));
  assign any_hit  = rise_hit || fall_hit;
  // A coincident clear consumes the old event, so the new one is not an overflow
  assign ovf_new  = any_hit && edge_q && !clr_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q  <= 1'b0;
      ovf_q   <= 1'b0;
      rseen_q <= 1'b0;
      fseen_q <= 1'b0;
    end else begin
      if (any_hit)       edge_q <= 1'b1;
      else if (clr_edge) edge_q <= 1'b0;

      if (ovf_new)       ovf_q <= 1'b1;
      else if (clr_ovf)  ovf_q <= 1'b0;

      if (rise_hit)      rseen_q <= 1'b1;
      else if (clr_edge) rseen_q <= 1'b0;

      if (fall_hit)      fseen_q <= 1'b1;
      else if (clr_edge) fseen_q <= 1'b0;
    end
  end

  // Function of registered flags and registered control only
  assign irq = ctrl.master_en &&
               ((edge_q && ctrl.edge_en) || (ovf_q && ctrl.ovf_en));
endmodule

// File: rtl/edgeirq_ctrl.sv
module edgeirq_ctrl
  import edgeirq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 12,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*PORT_W-1:0] lines_in,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  output logic                        irq
);
  localparam int unsigned NUM_LINES = NUM_PORTS * PORT_W;

  logic [NUM_LINES-1:0] rise, fall, rise_mask, fall_mask;
  ctrl_t                ctrl_q;
  logic                 clr_edge, clr_ovf;
  logic                 edge_q, ovf_q, rseen_q, fseen_q, any_hit, irq_w;
  status_t              status;

  edgeirq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .din(lines_in), .rise(rise), .fall(fall)
  );

  edgeirq_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .status_byte(PORT_W'(status)), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .ctrl(ctrl_q), .clr_edge(clr_edge), .clr_ovf(clr_ovf), .rdata(bus_rdata)
  );

  edgeirq_status #(.WIDTH(NUM_LINES)) u_stat (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .ctrl(ctrl_q),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .edge_q(edge_q), .ovf_q(ovf_q), .rseen_q(rseen_q), .fseen_q(fseen_q),
    .any_hit(any_hit), .irq(irq_w)
  );

  always_comb begin
    status           = '0;
    status.edge_ev   = edge_q;
    status.ovf       = ovf_q;
    status.pending   = irq_w;
    status.rise_seen = rseen_q;
    status.fall_seen = fseen_q;
  end

  assign irq = irq_w;
endmodule

// File: rtl/edgeirq_chk.sv
module edgeirq_chk
  import edgeirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        clr_bits,
  input logic              irq,
  input logic              master_en,
  input logic              edge_q,
  input logic              ovf_q,
  input logic              hit
);
  logic wr_clear, wr_clr_edge, wr_clr_ovf;
  assign wr_clear    = bus_wr && (bus_addr == ADDR_W'(ADR_CLEAR));
  assign wr_clr_edge = wr_clear && clr_bits[1];
  assign wr_clr_ovf  = wr_clear && clr_bits[0];

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst) irq |-> master_en); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> (edge_q || ovf_q)); // R8
  AST_EDGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(edge_q) |-> $past(hit)); // R2
  AST_HIT_KEEPS_EDGE: assert property (@(posedge clk) disable iff (rst) hit |=> edge_q); // R7
  AST_OVF_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst) $rose(ovf_q) |-> $past(edge_q)); // R5
  AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (rst) (wr_clr_edge && !hit) |=> !edge_q); // R6
  AST_CLEAR_OVF: assert property (@(posedge clk) disable iff (rst) (wr_clr_ovf && !hit) |=> !ovf_q); // R6
endmodule

bind edgeirq_ctrl edgeirq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .clr_bits(bus_wdata[3:2]), .irq(irq), .master_en(ctrl_q.master_en),
  .edge_q(edge_q), .ovf_q(ovf_q), .hit(any_hit)
);

// File: tb/sim_edgeirq_ctrl.sv
`timescale 1ns/1ps
module sim_edgeirq_ctrl;
  localparam int NP = 12;
  localparam int PW = 8;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP*PW-1:0] lines = '0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [PW-1:0]  bus_wdata = '0;
  logic [PW-1:0]  bus_rdata;
  logic           irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  edgeirq_ctrl #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .lines_in(lines), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: read data is registered at the edge that samples the address
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      #5;
      it = sb_q.pop_front();
      compared++;
      if (bus_rdata !== it.exp) begin
        mismatched++;
        $display("FAIL %s: rdata=0x%02h expected=0x%02h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = AW'(a);
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Change one line; return at the falling edge after status has updated
  task automatic set_line(input int idx, input logic v);
    @(negedge clk);
    lines[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    compared++;
    if (irq !== exp) begin
      mismatched++;
      $display("FAIL %s: irq=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  function automatic int rise_adr(int p); return 'h42 + 'h10 * p; endfunction
  function automatic int fall_adr(int p); return 'h43 + 'h10 * p; endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd('h02, 8'h00, "R1 status after reset");
    rd('h03, 8'h00, "R1 control after reset");
    rd(rise_adr(0), 8'h00, "R1 rise mask port0 after reset");
    rd(fall_adr(11), 8'h00, "R1 fall mask port11 after reset");

    // R9 / R11 independent port enables at their offsets
    wr(rise_adr(0), 8'h01);
    wr(fall_adr(1), 8'h80);
    wr(rise_adr(11), 8'hA5);
    rd(rise_adr(0), 8'h01, "R11 rise mask port0 at 0x42");
    rd(fall_adr(1), 8'h80, "R11 fall mask port1 at 0x53");
    rd(rise_adr(11), 8'hA5, "R11 rise mask port11 at 0xF2");
    rd(rise_adr(1), 8'h00, "R9 port1 rise untouched");
    rd(fall_adr(0), 8'h00, "R9 port0 fall untouched");
    rd('h01, 8'h00, "R11 clear register reads zero");

    // Control: edge_en, master, rise_en, fall_en
    wr('h03, 8'h1D);
    rd('h03, 8'h1D, "R11 control readback");

    // R2 rising edge on line 0
    set_line(0, 1'b1);
    chk_irq(1'b1, "R8 irq on edge");
    rd('h02, 8'h0D, "R2 rising edge status");

    // R6 clear edge
    wr('h01, 8'h08);
    chk_irq(1'b0, "R6 irq after clear");
    rd('h02, 8'h00, "R6 status after edge clear");

    // R4 masked lines
    set_line(1, 1'b1);
    rd('h02, 8'h00, "R4 rise on unmasked-off line ignored");
    set_line(0, 1'b0);
    rd('h02, 8'h00, "R4 fall with fall mask clear ignored");
    set_line(15, 1'b1);
    rd('h02, 8'h00, "R4 rise on line15 ignored");

    // R3 falling edge on line 15
    set_line(15, 1'b0);
    rd('h02, 8'h15, "R3 falling edge status");

    // R5 overflow
    set_line(0, 1'b1);
    rd('h02, 8'h1F, "R5 overflow status");

    // R6 selective clears
    wr('h01, 8'h04);
    rd('h02, 8'h1D, "R6 overflow-only clear");
    wr('h01, 8'h03);
    rd('h02, 8'h1D, "R6 other clear bits no effect");
    wr('h01, 8'h0C);
    rd('h02, 8'h00, "R6 combined clear");
    chk_irq(1'b0, "R6 irq after combined clear");

    // R4 global rising enable off
    wr('h03, 8'h15);
    set_line(0, 1'b0);
    set_line(0, 1'b1);
    rd('h02, 8'h00, "R4 global rise enable off");

    // R7 clear coincident with a new edge
    wr('h03, 8'h1D);
    set_line(0, 1'b0);
    set_line(0, 1'b1);
    rd('h02, 8'h0D, "R7 first edge before race");
    set_line(0, 1'b0);
    @(negedge clk);
    lines[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'('h01); bus_wdata = 8'h08;
    @(negedge clk);
    bus_wr = 1'b0;
    rd('h02, 8'h0D, "R7 new edge wins over clear");

    // R8 / R10 interrupt gating
    wr('h03, 8'h1C);
    chk_irq(1'b0, "R8 irq off without edge enable");
    rd('h02, 8'h09, "R8 pending bit follows irq");
    wr('h03, 8'h1D);
    chk_irq(1'b1, "R8 irq back on");
    wr('h03, 8'h00);
    chk_irq(1'b0, "R10 control zero drops irq");
    rd('h02, 8'h09, "R10 flags kept after control zero");

    // R8 overflow-only interrupt path
    wr('h03, 8'h0E);
    set_line(0, 1'b0);
    set_line(0, 1'b1);
    chk_irq(1'b1, "R8 irq from overflow enable");
    rd('h02, 8'h0F, "R5 overflow with ovf enable");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule